// File: doc/BRIEF.md
# Rewindable FIFO Buffer with Half-Full Indication

This block is a single-clock first-in first-out buffer that holds 4096 words of 9 bits. Words are stored in order and read back in order. Read and write addresses come only from two internal pointers. Each pointer carries one extra wrap bit above the address bits, so that a full buffer and an empty buffer can be told apart. Three active-low flags report the buffer state: empty, full, and more-than-half-full. A write that arrives while the buffer is full is dropped. A read that finds the buffer empty presents nothing.

A read operation lasts as long as `rd_en` is held high. While the buffer holds data, the word at the read pointer is shown on `rd_data`, and `rd_valid` marks it. `rd_valid` is a combinational output, not a registered one. The read pointer moves on only when the read is released. If a read is opened against an empty buffer and a write then lands, the new word shows at once and stays on the output until the read closes, even if more words are written in the meantime.

An active-low retransmit input rewinds the read pointer to location zero and leaves the write pointer alone, so the data written since reset can be replayed. An active-low reset clears both pointers. Reset and retransmit both win over any read or write requested in the same cycle.

Top module: `rewind_fifo`

## Requirements
- R1: Words are read back in the order they were accepted, with all 9 bits unchanged, up to 4096 stored words.
- R2: While `rst_n` is low, both pointers return to location zero. In the first cycle after reset, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_valid` is 0.
- R3: A write requested while the buffer holds 4096 words is dropped. The write pointer does not move and no stored word is changed.
- R4: With no reads after reset, `full_n` is still 1 after 4095 accepted writes and goes to 0 in the cycle after the 4096th accepted write.
- R5: `empty_n` is 0 exactly when the two pointers are equal. It goes to 1 in the cycle after a write is accepted into an empty buffer.
- R6: `half_n` goes to 0 in the cycle after the write that raises occupancy to 2049. It returns to 1 in the cycle after the read that lowers occupancy to 2048.
- R7: A cycle with `rt_n` at 0 sets the read pointer to zero and keeps the write pointer. In the next cycle all three flags follow the new pointer distance.
- R8: A read is open while `rd_en` is 1. `rd_valid` equals `rd_en` AND (buffer not empty), and `rd_data` holds the word at the read pointer for the whole open read. The read pointer advances on the first clock edge with `rd_en` at 0 after an open read that showed data. A read that never showed data moves nothing. A read opened against an empty buffer shows the first word written afterwards and keeps showing it until it closes.
- R9: When a read completion and an accepted write fall on the same clock edge, occupancy stays the same and the flags keep their values.
- R10: A cycle with `rst_n` at 0 or `rt_n` at 0 accepts no write and completes no read, whatever `wr_en` and `rd_en` request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read open while high; the read completes on release |
| rt_n | input | 1 | Retransmit (rewind the read pointer), active low |
| rd_data | output | 9 | Word at the read pointer; zero when `rd_valid` is 0 |
| rd_valid | output | 1 | `rd_data` carries a word |
| empty_n | output | 1 | Buffer empty, active low |
| full_n | output | 1 | Buffer full, active low |
| half_n | output | 1 | More than 2048 words stored, active low |

## Verification
A read completion and an accepted write can land on the same clock edge. The bench sets this up by releasing `rd_en` in the same cycle that it raises `wr_en`, with occupancy at 2049, just above the half-full boundary. It then checks that `half_n` stays low and that the replacement word comes out last, in order. The second collision is a control input against a data request. `wr_en` is held high through a reset cycle and through a retransmit cycle, and the empty flag and the later read stream show whether any write slipped in.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

  // Number of words held between two pointers that carry one wrap bit.
  function automatic int unsigned fill_level(input int unsigned wp,
                                             input int unsigned rp,
                                             input int unsigned aw);
    int unsigned mask;
    mask = (32'd1 << (aw + 1)) - 32'd1;
    return (wp - rp) & mask;
  endfunction

  function automatic int unsigned capacity(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

  function automatic bit over_half(input int unsigned fill,
                                   input int unsigned aw);
    return fill > (capacity(aw) >> 1);
  endfunction

endpackage

// File: rtl/rfifo_store.sv
module rfifo_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/rfifo_ptrs.sv
module rfifo_ptrs
  import rfifo_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic            rd_req,
  input  logic            rt_n,
  output logic            wr_acc,
  output logic            rd_done,
  output logic            rd_show,
  output logic            rt_evt,
  output logic [ADDR_W:0] wptr,
  output logic [ADDR_W:0] rptr,
  output logic [ADDR_W:0] wptr_nxt,
  output logic [ADDR_W:0] rptr_nxt
);
  localparam int unsigned CAP = 1 << ADDR_W;

  logic        rd_armed;
  logic        armed_nxt;
  int unsigned fill_now;

  assign fill_now = fill_level(int'(wptr), int'(rptr), ADDR_W);
  assign rt_evt   = !rt_n;
  assign rd_show  = rd_req && (fill_now != 0);
  assign wr_acc   = rt_n && wr_req && (fill_now != CAP);
  assign rd_done  = rt_n && rd_armed && !rd_req;

  assign wptr_nxt  = wptr + {{ADDR_W{1'b0}}, wr_acc};
  assign rptr_nxt  = rt_evt ? '0 : rptr + {{ADDR_W{1'b0}}, rd_done};
  assign armed_nxt = rt_n && rd_req && (rd_armed || rd_show);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      rd_armed <= 1'b0;
    end else begin
      wptr     <= wptr_nxt;
      rptr     <= rptr_nxt;
      rd_armed <= armed_nxt;
    end
  end

  // R1: occupancy never exceeds capacity
  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level(int'(wptr), int'(rptr), ADDR_W) <= CAP);

  // R3: a full buffer does not let a write move the write pointer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level(int'(wptr), int'(rptr), ADDR_W) == CAP && wr_req) |=> $stable(wptr));

  // R7: a retransmit rewinds the read side only
  a_r7_rewind_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rptr == '0));
  a_r7_keep_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> $stable(wptr));

  // R8: the read pointer moves only when a read closes
  a_r8_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_n && !rd_done) |=> $stable(rptr));

  // R10: a retransmit cycle accepts no write
  a_r10_rt_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |-> !wr_acc);

endmodule

// File: rtl/rfifo_flags.sv
module rfifo_flags
  import rfifo_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_acc,
  input  logic            rd_done,
  input  logic            rt_evt,
  input  logic [ADDR_W:0] wptr,
  input  logic [ADDR_W:0] rptr,
  input  logic [ADDR_W:0] wptr_nxt,
  input  logic [ADDR_W:0] rptr_nxt,
  output logic            empty_n,
  output logic            full_n,
  output logic            half_n
);
  localparam int unsigned CAP  = 1 << ADDR_W;
  localparam int unsigned HALF = CAP >> 1;

  int unsigned fill_nxt;
  logic        empty_q, full_q, half_q;
  logic        half_set, half_clr;

  assign fill_nxt = fill_level(int'(wptr_nxt), int'(rptr_nxt), ADDR_W);
  assign half_set = wr_acc && !rd_done && (fill_nxt == HALF + 1);
  assign half_clr = rd_done && !wr_acc && (fill_nxt == HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      empty_q <= (fill_nxt == 0);
      full_q  <= (fill_nxt == CAP);
      if (rt_evt)        half_q <= over_half(fill_nxt, ADDR_W);
      else if (half_set) half_q <= 1'b1;
      else if (half_clr) half_q <= 1'b0;
    end
  end

  assign empty_n = !empty_q;
  assign full_n  = !full_q;
  assign half_n  = !half_q;

  // R5: empty flag tracks pointer equality
  a_r5_empty_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) == (wptr == rptr));

  // R4: full flag tracks a distance of one full capacity
  a_r4_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) == (fill_level(int'(wptr), int'(rptr), ADDR_W) == CAP));

  // R6: the event-driven half flag agrees with the pointer distance
  a_r6_half_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_n) == over_half(fill_level(int'(wptr), int'(rptr), ADDR_W), ADDR_W));

  // R9: a read and a write on one edge leave the flags as they were
  a_r9_flags_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_done) |=> ($stable(empty_n) && $stable(full_n) && $stable(half_n)));

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rt_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  logic              wr_acc, rd_done, rd_show, rt_evt;
  logic [ADDR_W:0]   wptr, rptr, wptr_nxt, rptr_nxt;
  logic [DATA_W-1:0] cell_q;

  rfifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_en),
    .rd_req   (rd_en),
    .rt_n     (rt_n),
    .wr_acc   (wr_acc),
    .rd_done  (rd_done),
    .rd_show  (rd_show),
    .rt_evt   (rt_evt),
    .wptr     (wptr),
    .rptr     (rptr),
    .wptr_nxt (wptr_nxt),
    .rptr_nxt (rptr_nxt)
  );

  rfifo_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_acc   (wr_acc),
    .rd_done  (rd_done),
    .rt_evt   (rt_evt),
    .wptr     (wptr),
    .rptr     (rptr),
    .wptr_nxt (wptr_nxt),
    .rptr_nxt (rptr_nxt),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .half_n   (half_n)
  );

  rfifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (wptr[ADDR_W-1:0]),
    .wdata (wr_data),
    .raddr (rptr[ADDR_W-1:0]),
    .rdata (cell_q)
  );

  assign rd_valid = rd_show;
  assign rd_data  = rd_show ? cell_q : '0;

  // R8: the shown word does not change while a read stays open
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rt_n) |=> (!rd_valid || $stable(rd_data)));

  // R8: data is shown only against a non-empty buffer
  a_r8_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (empty_n && rd_en));

endmodule

// File: tb/rewind_fifo_test.sv
`timescale 1ns/1ps
module rewind_fifo_test;
  localparam int CAP  = 4096;
  localparam int HALF = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       rt_n = 1'b1;
  logic [8:0] rd_data;
  logic       rd_valid, empty_n, full_n, half_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [8:0] sb[$];
  logic [8:0] hist[$];

  always #2 clk = ~clk;

  rewind_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rt_n(rt_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    int cnt;
    cnt = sb.size();
    check(empty_n == (cnt != 0), {req, " empty_n"}, int'(empty_n), int'(cnt != 0));
    check(full_n == (cnt != CAP), {req, " full_n"}, int'(full_n), int'(cnt != CAP));
    check(half_n == !(cnt > HALF), {req, " half_n"}, int'(half_n), int'(!(cnt > HALF)));
  endtask

  // monitor: every shown word must be the oldest expected one (R1, R8)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) check(1'b0, "R8 word shown while model empty", int'(rd_data), 0);
      else check(rd_data == sb[0], "R1 order/data", int'(rd_data), int'(sb[0]));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    wr_en = 1'b0;
    sb.delete();
    hist.delete();
  endtask

  task automatic write_word(input logic [8:0] d);
    bit take;
    take = sb.size() < CAP;
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (take) begin
      sb.push_back(d);
      hist.push_back(d);
    end
  endtask

  task automatic read_word();
    bit had;
    had = sb.size() > 0;
    rd_en = 1'b1;
    @(negedge clk);
    check(rd_valid == had, "R8 rd_valid", int'(rd_valid), int'(had));
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    @(posedge clk);
    #1;
    if (had) void'(sb.pop_front());
  endtask

  task automatic retransmit();
    rt_n = 1'b0;
    @(posedge clk);
    #1;
    rt_n = 1'b1;
    sb = hist;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R2: reset state
    @(posedge clk); #1;
    do_reset();
    check(empty_n == 1'b0, "R2 empty_n", int'(empty_n), 0);
    check(full_n == 1'b1, "R2 full_n", int'(full_n), 1);
    check(half_n == 1'b1, "R2 half_n", int'(half_n), 1);
    check(rd_valid == 1'b0, "R2 rd_valid", int'(rd_valid), 0);

    // R1 / R5: small burst in order
    write_word(9'h1A5);
    check_flags("R5 after first write");
    write_word(9'h0F3);
    write_word(9'h100);
    repeat (3) read_word();
    check_flags("R5 after drain");

    // R8: read against empty moves nothing
    read_word();
    write_word(9'h055);
    read_word();
    check_flags("R8 after single");

    // R8: read flow-through from empty
    rd_en = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0, "R8 flow-through idle", int'(rd_valid), 0);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = 9'h111;
    @(posedge clk); #1;
    sb.push_back(9'h111); hist.push_back(9'h111);
    wr_data = 9'h122;
    @(posedge clk); #1;
    sb.push_back(9'h122); hist.push_back(9'h122);
    wr_data = 9'h133;
    @(negedge clk);
    check(rd_valid && rd_data == 9'h111, "R8 flow-through word held", int'(rd_data), 'h111);
    @(posedge clk); #1;
    sb.push_back(9'h133); hist.push_back(9'h133);
    wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk); #1;
    void'(sb.pop_front());
    read_word();
    read_word();
    check_flags("R8 flow-through drained");

    // R10: reset beats a write
    write_word(9'h0AA);
    wr_en = 1'b1; wr_data = 9'h0BB;
    do_reset();
    check(empty_n == 1'b0, "R10 reset over write", int'(empty_n), 0);
    // R10: retransmit beats a write
    wr_en = 1'b1; wr_data = 9'h0CC;
    retransmit();
    wr_en = 1'b0;
    check(empty_n == 1'b0, "R10 rt over write", int'(empty_n), 0);

    // R6 / R4: fill
    for (int i = 0; i < HALF; i++) write_word(9'((i * 7) & 'h1FF));
    check(half_n == 1'b1, "R6 at 2048", int'(half_n), 1);
    write_word(9'h1EE);
    check(half_n == 1'b0, "R6 at 2049", int'(half_n), 0);
    for (int i = HALF + 1; i < CAP - 1; i++) write_word(9'((i * 5 + 3) & 'h1FF));
    check(full_n == 1'b1, "R4 at 4095", int'(full_n), 1);
    write_word(9'h0D7);
    check(full_n == 1'b0, "R4 at 4096", int'(full_n), 0);
    // R3: write while full dropped
    write_word(9'h1FF);
    check_flags("R3 after refused write");

    // R7: retransmit after partial read
    repeat (10) read_word();
    check_flags("R7 before rewind");
    retransmit();
    check_flags("R7 after rewind");
    repeat (HALF - 1) read_word();
    check(half_n == 1'b0, "R6 at 2049 draining", int'(half_n), 0);

    // R9: read completion and write on one edge
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b1; wr_data = 9'h16C;
    @(posedge clk); #1;
    wr_en = 1'b0;
    void'(sb.pop_front());
    sb.push_back(9'h16C);
    check_flags("R9 collision");
    read_word();
    check(half_n == 1'b1, "R6 back at 2048", int'(half_n), 1);
    while (sb.size() > 0) read_word();
    check_flags("R5 empty after full drain");

    // R7: replay a short run
    do_reset();
    for (int i = 0; i < 5; i++) write_word(9'(9'h040 + i));
    repeat (5) read_word();
    check(empty_n == 1'b0, "R7 drained", int'(empty_n), 0);
    retransmit();
    check(empty_n == 1'b1, "R7 replay non-empty", int'(empty_n), 1);
    repeat (5) read_word();
    check_flags("R7 replay done");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule